// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU's 16-bit address bus and the memories of a small handheld-style system. For every address it names the target region, gives the local offset inside that region and gives the bank number to apply. It also flags regions that cannot be written and produces a write strobe that is gated off for those regions. The decode is purely combinational. It uses three pieces of state: a sticky boot-overlay disable flag, the selected upper ROM bank and the selected external RAM bank.

While the boot overlay is active, the lowest 256 bytes come from a boot ROM instead of ROM bank 0. Any nonzero byte written to the boot control register at 0xFF50 turns the overlay off until the next reset. The work RAM is visible at its own window and again at a mirror window higher up. The upper ROM window and the external RAM window each follow a bank register. The two bank registers are loaded through simple load-enable inputs.

Top module: `mem_map_decoder`

## Requirements
- R1: While `boot_active` is 1, addresses 0x0000–0x00FF decode to region code 0 (boot ROM) with offset equal to the address.
- R2: Addresses 0x0000–0x3FFF that are not taken by the boot overlay decode to region code 1 (fixed ROM), with offset equal to the address and bank 0.
- R3: Addresses 0x4000–0x7FFF decode to region code 2 (switchable ROM), with offset equal to the address minus 0x4000 and bank equal to the selected ROM bank.
- R4: Addresses 0x8000–0x9FFF decode to region code 3 (video RAM) with offset = address − 0x8000. Addresses 0xA000–0xBFFF decode to region code 4 (external RAM) with offset = address − 0xA000 and bank equal to the selected RAM bank.
- R5: Addresses 0xC000–0xDFFF decode to region code 5 (work RAM) with offset = address − 0xC000. Addresses 0xE000–0xFDFF also decode to region code 5, with offset = address − 0xE000.
- R6: Addresses 0xFE00–0xFEFF decode to region code 6 (object attribute RAM, offset = address − 0xFE00). Addresses 0xFF00–0xFF7F decode to code 7 (I/O page, offset = address − 0xFF00). Addresses 0xFF80–0xFFFF decode to code 8 (high RAM, offset = address − 0xFF80). The bank is 0 for every region except codes 2 and 4.
- R7: `read_only` is 1 for region codes 0, 1 and 2, and 0 for every other code.
- R8: `mem_we` equals `wr_en` when `read_only` is 0, and is 0 when `read_only` is 1.
- R9: A write with nonzero `wdata` to address 0xFF50 clears `boot_active` from the next clock edge. A write of 0x00 to that address leaves it unchanged. Once cleared, `boot_active` stays 0 until reset.
- R10: Reset sets `boot_active` to 1, the ROM bank to 1 and the RAM bank to 0. A bank load takes effect at the clock edge where its load input is high.
- R11: A selected ROM bank value of 0 is presented on `bank` as 1 in the switchable ROM window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | CPU write request |
| wdata | input | 8 | CPU write data |
| rom_bank_ld | input | 1 | Load enable for the ROM bank register |
| rom_bank_val | input | ROM_BANK_W | New ROM bank number |
| ram_bank_ld | input | 1 | Load enable for the RAM bank register |
| ram_bank_val | input | RAM_BANK_W | New RAM bank number |
| region | output | 4 | Region code (0 boot, 1 fixed ROM, 2 banked ROM, 3 video, 4 ext RAM, 5 work RAM, 6 object RAM, 7 I/O, 8 high RAM) |
| offset | output | 14 | Offset inside the region |
| bank | output | ROM_BANK_W | Bank number applied to the region |
| read_only | output | 1 | Region is ROM |
| mem_we | output | 1 | Write strobe forwarded to memory |
| boot_active | output | 1 | Boot overlay active |

## Verification
The bench builds the block with ROM_BANK_W = 3 and RAM_BANK_W = 2. With these widths every ROM bank (0 to 7) and every RAM bank (0 to 3) can be loaded and checked through `bank`, which includes the bank-0-as-1 substitution. The whole 64 KiB address space is swept twice, once with the overlay on and once with it off. Each region edge and the mirror are therefore checked against offsets computed arithmetically in the bench. Write strobes are swept at 256-byte steps, and the overlay latch is taken through zero writes, nonzero writes and a reset.

// File: rtl/mem_map_decoder.sv
module mem_map_decoder #(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  parameter logic [7:0] BOOT_REG = 8'h50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           addr,
  input  logic                  wr_en,
  input  logic [7:0]            wdata,
  input  logic                  rom_bank_ld,
  input  logic [ROM_BANK_W-1:0] rom_bank_val,
  input  logic                  ram_bank_ld,
  input  logic [RAM_BANK_W-1:0] ram_bank_val,
  output logic [3:0]            region,
  output logic [13:0]           offset,
  output logic [ROM_BANK_W-1:0] bank,
  output logic                  read_only,
  output logic                  mem_we,
  output logic                  boot_active
);
  localparam logic [3:0] RG_BOOT = 4'd0, RG_ROM0 = 4'd1, RG_ROMX = 4'd2,
                         RG_VRAM = 4'd3, RG_XRAM = 4'd4, RG_WRAM = 4'd5,
                         RG_OAM  = 4'd6, RG_IO   = 4'd7, RG_HRAM = 4'd8;
  localparam logic [15:0] BOOT_ADDR = {8'hFF, BOOT_REG};

  logic [ROM_BANK_W-1:0] rom_q, rom_eff;
  logic [RAM_BANK_W-1:0] ram_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_active <= 1'b1;
      rom_q       <= ROM_BANK_W'(1);
      ram_q       <= '0;
    end else begin
      if (wr_en && addr == BOOT_ADDR && wdata != 8'h00) boot_active <= 1'b0;
      if (rom_bank_ld) rom_q <= rom_bank_val;
      if (ram_bank_ld) ram_q <= ram_bank_val;
    end
  end

  assign rom_eff = (rom_q == '0) ? ROM_BANK_W'(1) : rom_q;

  always_comb begin
    region = RG_HRAM;
    offset = {7'd0, addr[6:0]};
    if (boot_active && addr[15:8] == 8'h00) begin
      region = RG_BOOT;
      offset = {6'd0, addr[7:0]};
    end else if (!addr[15]) begin
      region = addr[14] ? RG_ROMX : RG_ROM0;
      offset = addr[13:0];
    end else begin
      case (addr[14:13])
        2'b00: begin region = RG_VRAM; offset = {1'b0, addr[12:0]}; end
        2'b01: begin region = RG_XRAM; offset = {1'b0, addr[12:0]}; end
        2'b10: begin region = RG_WRAM; offset = {1'b0, addr[12:0]}; end
        default: begin
          if (addr[12:9] != 4'hF) begin
            region = RG_WRAM; offset = {1'b0, addr[12:0]};
          end else if (!addr[8]) begin
            region = RG_OAM;  offset = {6'd0, addr[7:0]};
          end else if (!addr[7]) begin
            region = RG_IO;   offset = {7'd0, addr[6:0]};
          end else begin
            region = RG_HRAM; offset = {7'd0, addr[6:0]};
          end
        end
      endcase
    end
  end

  always_comb begin
    case (region)
      RG_ROMX: bank = rom_eff;
      RG_XRAM: bank = ROM_BANK_W'(ram_q);
      default: bank = '0;
    endcase
  end

  assign read_only = (region == RG_BOOT) || (region == RG_ROM0) || (region == RG_ROMX);
  assign mem_we    = wr_en && !read_only;
endmodule

module mem_map_decoder_chk #(
  parameter int ROM_BANK_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           addr,
  input logic                  wr_en,
  input logic [7:0]            wdata,
  input logic [3:0]            region,
  input logic [ROM_BANK_W-1:0] bank,
  input logic                  read_only,
  input logic                  mem_we,
  input logic                  boot_active
);
  assert_rom_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_only |-> !mem_we);
  assert_ram_write_passed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_only && wr_en) |-> mem_we);
  assert_ro_matches_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    read_only == (region <= 4'd2));
  assert_boot_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |=> !boot_active);
  assert_boot_cleared_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boot_active) |-> $past(wr_en && addr == 16'hFF50 && wdata != 8'h00));
  assert_banked_rom_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 4'd2) |-> (bank != '0));
  assert_mirror_is_wram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hE000 && addr <= 16'hFDFF) |-> (region == 4'd5));
endmodule

bind mem_map_decoder mem_map_decoder_chk #(.ROM_BANK_W(ROM_BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .region(region), .bank(bank), .read_only(read_only), .mem_we(mem_we),
  .boot_active(boot_active)
);

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;
  localparam int RB = 3;
  localparam int XB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic          rom_bank_ld = 1'b0;
  logic [RB-1:0] rom_bank_val = '0;
  logic          ram_bank_ld = 1'b0;
  logic [XB-1:0] ram_bank_val = '0;
  logic [3:0]    region;
  logic [13:0]   offset;
  logic [RB-1:0] bank;
  logic          read_only, mem_we, boot_active;

  int n_chk = 0, n_bad = 0;
  logic m_boot = 1'b1;
  int m_rom = 1, m_ram = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mem_map_decoder #(.ROM_BANK_W(RB), .RAM_BANK_W(XB)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rom_bank_ld(rom_bank_ld), .rom_bank_val(rom_bank_val),
    .ram_bank_ld(ram_bank_ld), .ram_bank_val(ram_bank_val),
    .region(region), .offset(offset), .bank(bank), .read_only(read_only),
    .mem_we(mem_we), .boot_active(boot_active));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%0h expected=%0h", tag, addr, act, exp);
    end
  endtask

  task automatic check_addr();
    int a, r, o, b, ro;
    string tag;
    a = int'(addr);
    b = 0;
    if (m_boot && a < 'h100)  begin r = 0; o = a;           tag = "R1"; end
    else if (a < 'h4000)      begin r = 1; o = a;           tag = "R2"; end
    else if (a < 'h8000)      begin r = 2; o = a - 'h4000;  tag = "R3"; b = (m_rom == 0) ? 1 : m_rom; end
    else if (a < 'hA000)      begin r = 3; o = a - 'h8000;  tag = "R4"; end
    else if (a < 'hC000)      begin r = 4; o = a - 'hA000;  tag = "R4"; b = m_ram; end
    else if (a < 'hE000)      begin r = 5; o = a - 'hC000;  tag = "R5"; end
    else if (a < 'hFE00)      begin r = 5; o = a - 'hE000;  tag = "R5"; end
    else if (a < 'hFF00)      begin r = 6; o = a - 'hFE00;  tag = "R6"; end
    else if (a < 'hFF80)      begin r = 7; o = a - 'hFF00;  tag = "R6"; end
    else                      begin r = 8; o = a - 'hFF80;  tag = "R6"; end
    ro = (r <= 2) ? 1 : 0;
    check(int'(region) == r && int'(offset) == o && int'(bank) == b,
          {tag, " region/offset/bank"},
          (int'(region) << 20) | (int'(bank) << 16) | int'(offset),
          (r << 20) | (b << 16) | o);
    check(int'(read_only) == ro, "R7 read_only", int'(read_only), ro);
  endtask

  task automatic sweep_all();
    for (int a = 0; a < 65536; a++) begin
      addr = a[15:0];
      #1;
      check_addr();
    end
  endtask

  task automatic load_rom(input int v);
    @(negedge clk); rom_bank_ld = 1'b1; rom_bank_val = v[RB-1:0];
    @(negedge clk); rom_bank_ld = 1'b0; m_rom = v;
  endtask

  task automatic load_ram(input int v);
    @(negedge clk); ram_bank_ld = 1'b1; ram_bank_val = v[XB-1:0];
    @(negedge clk); ram_bank_ld = 1'b0; m_ram = v;
  endtask

  task automatic write_boot_reg(input logic [7:0] d);
    @(negedge clk); addr = 16'hFF50; wr_en = 1'b1; wdata = d;
    #1 check(mem_we == 1'b1, "R8 io write strobe", int'(mem_we), 1);
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    if (d != 8'h00) m_boot = 1'b0;
    #1 check(boot_active == m_boot, "R9 boot latch", int'(boot_active), int'(m_boot));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(boot_active == 1'b1, "R10 reset boot_active", int'(boot_active), 1);
    addr = 16'h4000; #1;
    check(int'(bank) == 1, "R10 reset rom bank", int'(bank), 1);
    addr = 16'hA000; #1;
    check(int'(bank) == 0, "R10 reset ram bank", int'(bank), 0);
    @(negedge clk); rst_n = 1'b1;

    sweep_all();

    for (int rb = 0; rb < (1 << RB); rb++) begin
      load_rom(rb);
      addr = 16'h5ABC; #1;
      check(int'(bank) == ((rb == 0) ? 1 : rb), "R3 R11 rom bank", int'(bank), (rb == 0) ? 1 : rb);
      addr = 16'h1234; #1;
      check(int'(bank) == 0, "R2 fixed bank", int'(bank), 0);
    end
    for (int xb = 0; xb < (1 << XB); xb++) begin
      load_ram(xb);
      addr = 16'hB123; #1;
      check(int'(bank) == xb, "R4 R10 ram bank", int'(bank), xb);
    end

    wr_en = 1'b1; wdata = 8'h00;
    for (int a = 0; a < 65536; a += 256) begin
      addr = a[15:0];
      #1;
      check(mem_we == (a >= 'h8000 || (a >= 'h100 ? 1'b0 : 1'b0)) ? 1'b1 : 1'b0,
            "R8 write strobe", int'(mem_we), (a >= 'h8000) ? 1 : 0);
    end
    wr_en = 1'b0;

    write_boot_reg(8'h00);
    addr = 16'h0042; #1; check_addr();
    write_boot_reg(8'h01);
    addr = 16'h0042; #1; check_addr();
    write_boot_reg(8'h00);
    write_boot_reg(8'hA5);

    load_rom(0);
    load_ram(3);
    sweep_all();

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; m_boot = 1'b1; m_rom = 1; m_ram = 0;
    #1 check(boot_active == 1'b1, "R10 R9 reset restores overlay", int'(boot_active), 1);
    addr = 16'h00FF; #1; check_addr();
    addr = 16'h0100; #1; check_addr();

    finish_run();
  end
endmodule